// File: doc/BRIEF.md
# Measurement Converter Control Sequencer

This block is the control state machine of a delta-sigma measurement converter. It runs from the master clock and takes three control pins: a convert request, a calibrate request and a polarity select. It sequences the power-up settling interval, a two-phase self-calibration (offset first, then gain) and conversion cycles. The block does no arithmetic. Where the filter or the calibration engine would be started or finished, it issues one-cycle strobes.

After reset the block stays in a settling interval. A command given during that interval is held until the interval ends. From standby, a calibration starts while both request pins are high. A rising convert edge with the calibrate pin low starts a conversion. A calibration chains straight into a conversion if the convert pin is still high when the calibration finishes. Holding convert high gives a continuous stream of conversions. Each conversion ends with a word-ready pulse. The polarity pin is sampled a fixed number of cycles before that pulse, and the sampled value sets the output format.

Top module: `adcseq_top`

## Requirements
- R1: After reset `state_o` reads 3 (wake-up) for exactly WAKE_CYC (1800) cycles. With no command it then reads 0 (standby). State codes: 0 standby, 1 calibrate, 2 convert, 3 wake-up.
- R2: A command seen during wake-up is remembered and carried out when wake-up ends. For example, both pins high during wake-up lead to calibration right after it.
- R3: A calibration lasts CAL_CYC (3246) cycles. `off_start_o` pulses in its first cycle, `gain_start_o` pulses OFFS_CYC (1623) cycles later, and `cal_done_o` pulses in its last cycle. No two of the five strobes are high in the same cycle.
- R4: A conversion started from standby lasts CONV_FIRST (1624) cycles. `conv_start_o` pulses in its first cycle and `word_rdy_o` pulses in its last cycle.
- R5: In the last cycle of a calibration the synchronized convert level is examined. If it is high, a conversion follows in the next cycle; otherwise the block returns to standby.
- R6: During calibration, a convert rising edge with calibrate high restarts the calibration from its first cycle. A convert rising edge with calibrate low has no effect.
- R7: During a conversion, a convert rising edge with calibrate low abandons that conversion and starts a new one of CONV_FIRST cycles. With calibrate high, the same edge starts a calibration.
- R8: If convert is still high when a conversion ends, the next conversion starts at once and lasts CONV_NEXT (1622) cycles, so successive `word_rdy_o` pulses are 1622 cycles apart.
- R9: Internal logic acts at half rate. A phase bit toggles every cycle and is 0 in the first cycle after reset, and a start from standby happens only when it is 1. A pin edge therefore takes 3 or 4 clock edges to produce `conv_start_o`.
- R10: `fmt_bipolar_o` takes the value of `bipolar_i` sampled FMT_LEAD (82) cycles before the `word_rdy_o` cycle. It holds that value at all other times. The pin is not latched earlier.
- R11: Convert and calibrate pass through a two-flop synchronizer, so a pin change has no effect on `state_o` within two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_i | input | 1 | Convert request pin (asynchronous) |
| cal_i | input | 1 | Calibrate request pin (asynchronous) |
| bipolar_i | input | 1 | Polarity select, 1 = bipolar (offset binary) |
| state_o | output | 2 | Current state code |
| off_start_o | output | 1 | Offset calibration phase start strobe |
| gain_start_o | output | 1 | Gain calibration phase start strobe |
| cal_done_o | output | 1 | Last cycle of calibration |
| conv_start_o | output | 1 | First cycle of a conversion |
| word_rdy_o | output | 1 | End of conversion, word-ready request to the output port |
| fmt_bipolar_o | output | 1 | Polarity sampled for the current word |

## Verification
The bench goes after the edges in the command decode. A command given in the settling window must not be lost. A design that forgot it would sit in standby. A low-calibrate convert edge during calibration must be ignored, or the calibration would be cut short into a conversion. A repeated edge must restart a calibration, or the strobes would show an unrestarted timeline. Back-to-back spacing and the first-conversion length are measured separately, so swapping 1622 and 1624 shows up as a spacing error. The polarity pin is toggled on both sides of its sample point, so a design that latched it at conversion start would report the wrong format.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAL  = 2'd1,
        ST_CONV = 2'd2,
        ST_WAKE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic conv;       // synchronized convert level
        logic cal;        // synchronized calibrate level
        logic conv_rise;  // rising edge of synchronized convert
    } cmd_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync
    import adcseq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic conv_pin,
    input  logic cal_pin,
    output cmd_t cmd
);

    logic [STAGES-1:0] cv_q;
    logic [STAGES-1:0] cl_q;
    logic              cv_prev;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("adcseq_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cv_q    <= '0;
            cl_q    <= '0;
            cv_prev <= 1'b0;
        end else begin
            cv_q    <= {cv_q[STAGES-2:0], conv_pin};
            cl_q    <= {cl_q[STAGES-2:0], cal_pin};
            cv_prev <= cv_q[STAGES-1];
        end
    end

    assign cmd.conv      = cv_q[STAGES-1];
    assign cmd.cal       = cl_q[STAGES-1];
    assign cmd.conv_rise = cv_q[STAGES-1] & ~cv_prev;

    // R11: an edge lasts one cycle only
    p_rise_single_r11: assert property (@(posedge clk) disable iff (rst)
        cmd.conv_rise |=> !cmd.conv_rise);

endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int WAKE_CYC   = 1800,
    parameter int CAL_CYC    = 3246,
    parameter int OFFS_CYC   = 1623,
    parameter int CONV_FIRST = 1624,
    parameter int CONV_NEXT  = 1622,
    parameter int FMT_LEAD   = 82
) (
    input  logic       clk,
    input  logic       rst,
    input  cmd_t       cmd,
    output seq_state_e state,
    output logic       off_start,
    output logic       gain_start,
    output logic       cal_done,
    output logic       conv_start,
    output logic       conv_end,
    output logic       fmt_sample
);

    localparam int LONGEST = max_of(max_of(WAKE_CYC, CAL_CYC), CONV_FIRST);
    localparam int CW      = $clog2(LONGEST) + 1;
    localparam logic [CW-1:0] WAKE_LD  = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0] CAL_LD   = CW'(CAL_CYC - 1);
    localparam logic [CW-1:0] GAIN_AT  = CW'(CAL_CYC - 1 - OFFS_CYC);
    localparam logic [CW-1:0] CONV1_LD = CW'(CONV_FIRST - 1);
    localparam logic [CW-1:0] CONVN_LD = CW'(CONV_NEXT - 1);
    localparam logic [CW-1:0] FMT_AT   = CW'(FMT_LEAD);

    seq_state_e      nstate;
    logic [CW-1:0]   cnt, ncnt;
    logic            fresh, nfresh;
    logic            phase;
    logic            pend_cal, pend_conv, npend_cal, npend_conv;
    logic            want_cal, want_conv, both_hi;

    assign both_hi   = cmd.conv & cmd.cal;
    assign want_cal  = pend_cal | both_hi;
    assign want_conv = pend_conv | (cmd.conv_rise & ~cmd.cal);

    always_comb begin
        nstate     = state;
        ncnt       = (cnt == '0) ? cnt : cnt - 1'b1;
        nfresh     = 1'b0;
        npend_cal  = pend_cal;
        npend_conv = pend_conv;
        unique case (state)
            ST_WAKE: begin
                npend_cal  = want_cal;
                npend_conv = want_conv;
                if (cnt == '0) nstate = ST_IDLE;
            end
            ST_IDLE: begin
                if (phase && want_cal) begin
                    nstate = ST_CAL;  ncnt = CAL_LD;   nfresh = 1'b1;
                    npend_cal = 1'b0; npend_conv = 1'b0;
                end else if (phase && want_conv) begin
                    nstate = ST_CONV; ncnt = CONV1_LD; nfresh = 1'b1;
                    npend_cal = 1'b0; npend_conv = 1'b0;
                end else begin
                    npend_cal  = want_cal;
                    npend_conv = want_conv;
                end
            end
            ST_CAL: begin
                if (cmd.conv_rise && cmd.cal) begin
                    ncnt = CAL_LD; nfresh = 1'b1;
                end else if (cnt == '0) begin
                    if (cmd.conv) begin
                        nstate = ST_CONV; ncnt = CONV1_LD; nfresh = 1'b1;
                    end else begin
                        nstate = ST_IDLE;
                    end
                end
            end
            ST_CONV: begin
                if (cmd.conv_rise && cmd.cal) begin
                    nstate = ST_CAL; ncnt = CAL_LD; nfresh = 1'b1;
                end else if (cmd.conv_rise) begin
                    ncnt = CONV1_LD; nfresh = 1'b1;
                end else if (cnt == '0) begin
                    if (cmd.conv) begin
                        ncnt = CONVN_LD; nfresh = 1'b1;
                    end else begin
                        nstate = ST_IDLE;
                    end
                end
            end
            default: nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_WAKE;
            cnt       <= WAKE_LD;
            fresh     <= 1'b0;
            phase     <= 1'b0;
            pend_cal  <= 1'b0;
            pend_conv <= 1'b0;
        end else begin
            state     <= nstate;
            cnt       <= ncnt;
            fresh     <= nfresh;
            phase     <= ~phase;
            pend_cal  <= npend_cal;
            pend_conv <= npend_conv;
        end
    end

    assign off_start  = (state == ST_CAL)  && fresh;
    assign gain_start = (state == ST_CAL)  && (cnt == GAIN_AT) && !fresh;
    assign cal_done   = (state == ST_CAL)  && (cnt == '0);
    assign conv_start = (state == ST_CONV) && fresh;
    assign conv_end   = (state == ST_CONV) && (cnt == '0);
    assign fmt_sample = (state == ST_CONV) && (cnt == FMT_AT);

    p_wake_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE && cnt != '0) |=> state == ST_WAKE);

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({off_start, gain_start, cal_done, conv_start, conv_end}));

    p_cal_chain_r5: assert property (@(posedge clk) disable iff (rst)
        (cal_done && cmd.conv && !cmd.conv_rise) |=> conv_start);

    p_cal_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAL && cmd.conv_rise && cmd.cal) |=> off_start);

    p_conv_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV && cmd.conv_rise && !cmd.cal) |=> conv_start);

    p_idle_phase_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !phase) |=> state == ST_IDLE);

endmodule

// File: rtl/adcseq_fmt.sv
module adcseq_fmt (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic bp_pin,
    output logic fmt_q
);

    always_ff @(posedge clk) begin
        if (rst)         fmt_q <= 1'b0;
        else if (sample) fmt_q <= bp_pin;
    end

    p_fmt_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(fmt_q));

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYC    = 1800,
    parameter int CAL_CYC     = 3246,
    parameter int OFFS_CYC    = 1623,
    parameter int CONV_FIRST  = 1624,
    parameter int CONV_NEXT   = 1622,
    parameter int FMT_LEAD    = 82
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       conv_i,
    input  logic       cal_i,
    input  logic       bipolar_i,
    output logic [1:0] state_o,
    output logic       off_start_o,
    output logic       gain_start_o,
    output logic       cal_done_o,
    output logic       conv_start_o,
    output logic       word_rdy_o,
    output logic       fmt_bipolar_o
);

    cmd_t       cmd;
    seq_state_e st;
    logic       sample;

    adcseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .conv_pin(conv_i), .cal_pin(cal_i), .cmd(cmd)
    );

    adcseq_fsm #(
        .WAKE_CYC(WAKE_CYC), .CAL_CYC(CAL_CYC), .OFFS_CYC(OFFS_CYC),
        .CONV_FIRST(CONV_FIRST), .CONV_NEXT(CONV_NEXT), .FMT_LEAD(FMT_LEAD)
    ) u_fsm (
        .clk(clk), .rst(rst), .cmd(cmd), .state(st),
        .off_start(off_start_o), .gain_start(gain_start_o),
        .cal_done(cal_done_o), .conv_start(conv_start_o),
        .conv_end(word_rdy_o), .fmt_sample(sample)
    );

    adcseq_fmt u_fmt (
        .clk(clk), .rst(rst), .sample(sample), .bp_pin(bipolar_i),
        .fmt_q(fmt_bipolar_o)
    );

    assign state_o = st;

endmodule

// File: tb/adcseq_top_tb.sv
module adcseq_top_tb;

    localparam int CLK_P = 10;
    localparam int WAKE  = 1800;
    localparam int CALN  = 3246;
    localparam int OFFS  = 1623;
    localparam int CV1   = 1624;
    localparam int CVN   = 1622;
    localparam int LEAD  = 82;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic conv_i = 1'b0, cal_i = 1'b0, bipolar_i = 1'b0;
    logic [1:0] state_o;
    logic off_start_o, gain_start_o, cal_done_o, conv_start_o, word_rdy_o, fmt_bipolar_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    adcseq_top u_dut (
        .clk(clk), .rst(rst), .conv_i(conv_i), .cal_i(cal_i), .bipolar_i(bipolar_i),
        .state_o(state_o), .off_start_o(off_start_o), .gain_start_o(gain_start_o),
        .cal_done_o(cal_done_o), .conv_start_o(conv_start_o),
        .word_rdy_o(word_rdy_o), .fmt_bipolar_o(fmt_bipolar_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // behavioural reference: elapsed-time counters and a pin history
    int m_st, m_el, m_len, m_ph, m_fmt;
    bit m_pc, m_pv;
    bit hc[3];
    bit ha[3];

    task automatic m_begin(input int kind, input int len);
        m_st = kind; m_el = 0; m_len = len;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_st = 3; m_el = 0; m_len = WAKE; m_ph = 0; m_fmt = 0;
            m_pc = 0; m_pv = 0;
            foreach (hc[i]) begin hc[i] = 0; ha[i] = 0; end
        end else begin
            bit lvl_c, lvl_a, edge_c, fin, acted;
            lvl_c  = hc[1];
            lvl_a  = ha[1];
            edge_c = hc[1] && !hc[2];
            fin    = (m_el == m_len - 1);
            acted  = 0;
            if (m_st == 2 && m_el == m_len - 1 - LEAD) m_fmt = bipolar_i;
            case (m_st)
                3: begin
                    if (lvl_c && lvl_a) m_pc = 1;
                    if (edge_c && !lvl_a) m_pv = 1;
                    if (fin) begin m_st = 0; acted = 1; end
                end
                0: begin
                    if (lvl_c && lvl_a) m_pc = 1;
                    if (edge_c && !lvl_a) m_pv = 1;
                    if (m_ph == 1 && m_pc) begin m_begin(1, CALN); m_pc = 0; m_pv = 0; acted = 1; end
                    else if (m_ph == 1 && m_pv) begin m_begin(2, CV1); m_pc = 0; m_pv = 0; acted = 1; end
                end
                1: begin
                    if (edge_c && lvl_a) begin m_begin(1, CALN); acted = 1; end
                    else if (fin) begin
                        if (lvl_c) m_begin(2, CV1); else m_st = 0;
                        acted = 1;
                    end
                end
                default: begin
                    if (edge_c && lvl_a) begin m_begin(1, CALN); acted = 1; end
                    else if (edge_c) begin m_begin(2, CV1); acted = 1; end
                    else if (fin) begin
                        if (lvl_c) m_begin(2, CVN); else m_st = 0;
                        acted = 1;
                    end
                end
            endcase
            if (!acted) m_el++;
            m_ph = 1 - m_ph;
            hc[2] = hc[1]; hc[1] = hc[0]; hc[0] = conv_i;
            ha[2] = ha[1]; ha[1] = ha[0]; ha[0] = cal_i;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            string st_tag;
            case (m_st)
                3: st_tag = "R1 state";
                1: st_tag = "R3 state";
                2: st_tag = "R4 state";
                default: st_tag = "R5 state";
            endcase
            chk(st_tag, int'(state_o), m_st);
            chk("R3 offset strobe", int'(off_start_o), int'(m_st == 1 && m_el == 0));
            chk("R3 gain strobe", int'(gain_start_o), int'(m_st == 1 && m_el == OFFS));
            chk("R3 cal done", int'(cal_done_o), int'(m_st == 1 && m_el == m_len - 1));
            chk("R7 conv start", int'(conv_start_o), int'(m_st == 2 && m_el == 0));
            chk("R4 word ready", int'(word_rdy_o), int'(m_st == 2 && m_el == m_len - 1));
            chk("R10 format", int'(fmt_bipolar_o), m_fmt);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rdy();
        for (int i = 0; i < 6000 && !word_rdy_o; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int t0, t1, t2, n;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 reset state", int'(state_o), 3);
        // R2: command during wake-up
        step(100);
        cal_i = 1'b1; conv_i = 1'b1;
        for (int i = 0; i < 3000 && state_o == 2'd3; i++) step(1);
        chk("R1 wake length", cyc >= WAKE ? 1 : 0, 1);
        for (int i = 0; i < 2 && state_o != 2'd1; i++) step(1);
        chk("R2 held command runs", int'(state_o), 1);
        step(50);
        cal_i = 1'b0;
        bipolar_i = 1'b1;
        // R5 chain, R8 spacing
        wait_rdy(); t0 = cyc; step(1);
        bipolar_i = 1'b0;
        wait_rdy(); t1 = cyc; step(1);
        step(CVN - LEAD - 20);
        bipolar_i = 1'b1;               // before sample point
        wait_rdy(); t2 = cyc; step(1);
        chk("R8 spacing a", t1 - t0, CVN);
        chk("R8 spacing b", t2 - t1, CVN);
        chk("R10 late polarity", int'(fmt_bipolar_o), 1);
        bipolar_i = 1'b0;
        step(CVN - LEAD + 10);
        bipolar_i = 1'b1;               // after sample point
        conv_i = 1'b0;
        wait_rdy(); step(1);
        chk("R10 after-sample change", int'(fmt_bipolar_o), 0);
        chk("R5 back to standby", int'(state_o), 0);
        // R9, R11: start from standby
        step(7);
        conv_i = 1'b1;
        n = 0;
        step(2); n = 2;
        chk("R11 no effect within two edges", int'(state_o), 0);
        while (!conv_start_o && n < 10) begin step(1); n++; end
        chk("R9 start delay low", n >= 3 ? 1 : 0, 1);
        chk("R9 start delay high", n <= 4 ? 1 : 0, 1);
        // R7: restart during conversion
        step(300);
        conv_i = 1'b0; step(5);
        conv_i = 1'b1; step(4);
        chk("R7 restarted conversion", int'(state_o), 2);
        conv_i = 1'b0;
        wait_rdy(); step(2);
        chk("R4 idle after single", int'(state_o), 0);
        // R6: calibration from standby, ignored and honoured edges
        cal_i = 1'b1; step(2); conv_i = 1'b1;
        for (int i = 0; i < 8 && state_o != 2'd1; i++) step(1);
        chk("R3 calibration entered", int'(state_o), 1);
        cal_i = 1'b0; conv_i = 1'b0; step(400);
        conv_i = 1'b1; step(10);
        chk("R6 low-cal edge ignored", int'(state_o), 1);
        conv_i = 1'b0; step(200);
        cal_i = 1'b1; step(3); conv_i = 1'b1;
        n = 0;
        while (!off_start_o && n < 10) begin step(1); n++; end
        chk("R6 restart strobe", int'(off_start_o), 1);
        cal_i = 1'b0; conv_i = 1'b0;
        for (int i = 0; i < 4000 && !cal_done_o; i++) step(1);
        step(2);
        chk("R5 standby after cal", int'(state_o), 0);
        step(20);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule